// File: doc/BRIEF.md
# ADC Start-Up and Data-Ready Sequencer

This block times the digital back end of one delta-sigma converter channel after any kind of reset. It counts modulator ticks, keeps the decimation filter from seeing modulator samples until a fixed settling interval has passed, and then marks each completed output period with an active-low data-ready strobe. A power-on reset adds a supply-ramp wait in front of the settling interval. A command reset or a pin reset starts directly with the settling interval.

For the first two outputs after a reset the block selects the fast-settling filter path. After that it selects the normal path. Those first two strobes still fire, but their data has not settled, so a status flag rises with the third strobe and marks it as the first trustworthy sample. The output period is chosen from eight oversampling ratios through a 3-bit code. A reset that arrives at any point restarts the whole sequence.

Top module: `adc_start_sequencer`

## Requirements
- R1: After `por_n` is released, `filt_en` stays low for the first PWR_WAIT + 300 modulator ticks (default PWR_WAIT = 1024). It rises in the cycle after the clock edge that samples the last of those ticks.
- R2: After a `cmd_rst` or `pin_rst` pulse, `filt_en` stays low for exactly 300 modulator ticks with no power-on wait, and then rises. This also holds when the pulse arrives during the power-on wait.
- R3: Once `filt_en` is high, `drdy_n` falls on the OSR-th tick and on every OSR-th tick after that, in the cycle after that tick is sampled.
- R4: After each falling edge, `drdy_n` returns high on the DRDY_LOW-th following tick (default 4).
- R5: `drdy_n` is high while `filt_en` is low, including during reset.
- R6: `fast_sel` is high from the rise of `filt_en` until the second falling edge of `drdy_n`. It is low otherwise.
- R7: `data_valid` rises together with the third falling edge of `drdy_n` after a reset and stays high until the next reset.
- R8: `osr_code` selects the output period in ticks. Codes 0 to 6 give 128 shifted left by the code (128 up to 8192). Code 7 gives 16256.
- R9: A `cmd_rst` or `pin_rst` pulse takes priority over a coincident tick. In the next cycle `filt_en`, `fast_sel` and `data_valid` are low and `drdy_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| mod_tick | input | 1 | One-cycle pulse per modulator period |
| osr_code | input | 3 | Oversampling ratio selection |
| cmd_rst | input | 1 | Command reset, one-cycle pulse |
| pin_rst | input | 1 | Pin reset, one-cycle pulse |
| filt_en | output | 1 | Modulator samples are passed to the filter |
| fast_sel | output | 1 | Fast-settling filter path selected |
| drdy_n | output | 1 | Active-low data-ready strobe |
| data_valid | output | 1 | Outputs from the current strobe on are settled |

## Verification
The assertions assume that `mod_tick` is a single-cycle pulse, that `cmd_rst` and `pin_rst` are synchronous to `clk`, and that `osr_code` does not change while a sequence is running. The stimulus changes `osr_code` only in the same cycle as a reset pulse. Ticks are issued at random densities or back to back, and every reset is a single-cycle synchronous pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int OSR_W = 14;

   typedef enum logic [1:0] {
      PH_SUPPLY = 2'd0,
      PH_SETTLE = 2'd1,
      PH_RUN    = 2'd2
   } seq_phase_t;

   function automatic logic [OSR_W-1:0] osr_period(input logic [2:0] code);
      if (code == 3'd7) return OSR_W'(16256);
      else              return OSR_W'(128) << code;
   endfunction

endpackage

// File: rtl/adc_seq_osr_map.sv
module adc_seq_osr_map
   import adc_seq_pkg::*;
(
   input  logic [2:0]       code,
   output logic [OSR_W-1:0] period
);
   localparam int N_CODES = 8;

   logic [OSR_W-1:0] table_q [N_CODES];

   for (genvar i = 0; i < N_CODES; i++) begin : g_tbl
      assign table_q[i] = osr_period(3'(i));
   end

   assign period = table_q[code];

endmodule

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
   import adc_seq_pkg::*;
#(
   parameter int PWR_WAIT   = 1024,
   parameter int BASE_WAIT  = 256,
   parameter int EXTRA_WAIT = 44
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick,
   input  logic restart,
   output logic run
);
   localparam int INIT_WAIT = BASE_WAIT + EXTRA_WAIT;
   localparam int MAX_WAIT  = (PWR_WAIT > INIT_WAIT) ? PWR_WAIT : INIT_WAIT;
   localparam int CW        = $clog2(MAX_WAIT + 1);

   seq_phase_t       phase_q;
   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    limit;

   always_comb begin
      limit = (phase_q == PH_SUPPLY) ? CW'(PWR_WAIT - 1) : CW'(INIT_WAIT - 1);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase_q <= PH_SUPPLY;
         cnt_q   <= '0;
      end else if (restart) begin
         phase_q <= PH_SETTLE;
         cnt_q   <= '0;
      end else if (tick && phase_q != PH_RUN) begin
         if (cnt_q == limit) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_SUPPLY) ? PH_SETTLE : PH_RUN;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign run = (phase_q == PH_RUN);

   AST_RUN_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
      $rose(run) |-> $past(tick) && !$past(restart)); // R1
   AST_RESTART_STOPS: assert property (@(posedge clk) disable iff (!por_n)
      restart |=> !run); // R9

endmodule

// File: rtl/adc_seq_strobe.sv
module adc_seq_strobe
   import adc_seq_pkg::*;
#(
   parameter int DRDY_LOW     = 4,
   parameter int FAST_OUTS    = 2,
   parameter int DISCARD_OUTS = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             run,
   input  logic [OSR_W-1:0] period,
   output logic             drdy_n,
   output logic             fast_sel,
   output logic             data_valid
);
   localparam int OC_MAX = DISCARD_OUTS + 1;
   localparam int OCW    = $clog2(OC_MAX + 1);

   logic [OSR_W-1:0] per_q;
   logic [OCW-1:0]   outs_q;
   logic             valid_q;
   logic             out_evt;
   logic             clear;

   assign clear   = restart || !run;
   assign out_evt = run && tick && !restart && (per_q >= period - 1'b1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       per_q <= '0;
      else if (clear)   per_q <= '0;
      else if (tick)    per_q <= out_evt ? '0 : per_q + 1'b1;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         outs_q  <= '0;
         valid_q <= 1'b0;
      end else if (restart) begin
         outs_q  <= '0;
         valid_q <= 1'b0;
      end else if (out_evt) begin
         if (outs_q == OCW'(DISCARD_OUTS)) valid_q <= 1'b1;
         if (outs_q < OCW'(OC_MAX))        outs_q  <= outs_q + 1'b1;
      end
   end

   if (DRDY_LOW == 1) begin : g_low_single
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)        drdy_n <= 1'b1;
         else if (clear)    drdy_n <= 1'b1;
         else if (out_evt)  drdy_n <= 1'b0;
         else if (tick)     drdy_n <= 1'b1;
      end
   end else begin : g_low_count
      localparam int LW = $clog2(DRDY_LOW + 1);
      logic [LW-1:0] low_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            drdy_n <= 1'b1;
            low_q  <= '0;
         end else if (clear) begin
            drdy_n <= 1'b1;
            low_q  <= '0;
         end else if (out_evt) begin
            drdy_n <= 1'b0;
            low_q  <= LW'(DRDY_LOW);
         end else if (tick && low_q != '0) begin
            low_q <= low_q - 1'b1;
            if (low_q == LW'(1)) drdy_n <= 1'b1;
         end
      end
   end

   assign fast_sel   = run && (outs_q < OCW'(FAST_OUTS));
   assign data_valid = valid_q;

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!por_n)
      !run |-> drdy_n); // R5
   AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
      $fell(drdy_n) |-> $past(tick) && $past(run)); // R3
   AST_VALID_WITH_EDGE: assert property (@(posedge clk) disable iff (!por_n)
      $rose(data_valid) |-> $fell(drdy_n)); // R7
   AST_FAST_VALID_EXCL: assert property (@(posedge clk) disable iff (!por_n)
      !(fast_sel && data_valid)); // R6
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
      restart |=> drdy_n && !data_valid); // R9

endmodule

// File: rtl/adc_start_sequencer.sv
module adc_start_sequencer
   import adc_seq_pkg::*;
#(
   parameter int PWR_WAIT     = 1024,
   parameter int BASE_WAIT    = 256,
   parameter int EXTRA_WAIT   = 44,
   parameter int DRDY_LOW     = 4,
   parameter int FAST_OUTS    = 2,
   parameter int DISCARD_OUTS = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       mod_tick,
   input  logic [2:0] osr_code,
   input  logic       cmd_rst,
   input  logic       pin_rst,
   output logic       filt_en,
   output logic       fast_sel,
   output logic       drdy_n,
   output logic       data_valid
);
   localparam int MIN_OSR = 128;

   if (PWR_WAIT < 1 || BASE_WAIT + EXTRA_WAIT < 1) begin : g_bad_wait
      $error("adc_start_sequencer: wait counts must be at least 1");
   end
   if (DRDY_LOW < 1 || DRDY_LOW >= MIN_OSR) begin : g_bad_low
      $error("adc_start_sequencer: DRDY_LOW must lie in 1..127");
   end
   if (FAST_OUTS > DISCARD_OUTS) begin : g_bad_fast
      $error("adc_start_sequencer: FAST_OUTS may not exceed DISCARD_OUTS");
   end

   logic             restart;
   logic             run;
   logic [OSR_W-1:0] period;

   assign restart = cmd_rst || pin_rst;

   adc_seq_osr_map u_map (
      .code   (osr_code),
      .period (period)
   );

   adc_seq_phase #(
      .PWR_WAIT   (PWR_WAIT),
      .BASE_WAIT  (BASE_WAIT),
      .EXTRA_WAIT (EXTRA_WAIT)
   ) u_phase (
      .clk     (clk),
      .por_n   (por_n),
      .tick    (mod_tick),
      .restart (restart),
      .run     (run)
   );

   adc_seq_strobe #(
      .DRDY_LOW     (DRDY_LOW),
      .FAST_OUTS    (FAST_OUTS),
      .DISCARD_OUTS (DISCARD_OUTS)
   ) u_strobe (
      .clk        (clk),
      .por_n      (por_n),
      .tick       (mod_tick),
      .restart    (restart),
      .run        (run),
      .period     (period),
      .drdy_n     (drdy_n),
      .fast_sel   (fast_sel),
      .data_valid (data_valid)
   );

   assign filt_en = run;

   AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
      period >= OSR_W'(MIN_OSR)); // R8

endmodule

// File: tb/adc_start_sequencer_test.sv
`timescale 1ns/1ps
module adc_start_sequencer_test;
   localparam int PW    = 1024;
   localparam int INITW = 300;
   localparam int DL    = 4;
   localparam int MAX_CYCLES = 190000;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic mod_tick = 1'b0;
   logic cmd_rst = 1'b0;
   logic pin_rst = 1'b0;
   logic [2:0] osr_code = 3'd0;
   logic filt_en, fast_sel, drdy_n, data_valid;

   always #2 clk = ~clk;

   adc_start_sequencer uut (
      .clk(clk), .por_n(por_n), .mod_tick(mod_tick), .osr_code(osr_code),
      .cmd_rst(cmd_rst), .pin_rst(pin_rst), .filt_en(filt_en),
      .fast_sel(fast_sel), .drdy_n(drdy_n), .data_valid(data_valid)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   int m_ph, m_cnt, m_per, m_low, m_outs;
   bit m_valid, m_drdy;
   int tick_total, last_fall, falls;
   bit prev_drdy;
   string en_tag;

   function automatic int osr_of(input int c);
      return (c == 7) ? 16256 : (128 << c);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_por();
      m_ph = 0; m_cnt = 0; m_per = 0; m_low = 0; m_outs = 0;
      m_valid = 0; m_drdy = 1; last_fall = -1; falls = 0; prev_drdy = 1;
      en_tag = "R1 filt_en";
   endtask

   task automatic model_edge(input bit t, input bit r);
      if (r) begin
         m_ph = 1; m_cnt = 0; m_per = 0; m_low = 0; m_outs = 0;
         m_valid = 0; m_drdy = 1; last_fall = -1; falls = 0;
         en_tag = "R2 filt_en";
      end else if (t) begin
         tick_total++;
         case (m_ph)
            0: if (m_cnt == PW - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
            1: if (m_cnt == INITW - 1) begin m_ph = 2; m_cnt = 0; m_per = 0; end else m_cnt++;
            default: begin
               if (m_low > 0) begin
                  m_low--;
                  if (m_low == 0) m_drdy = 1;
               end
               if (m_per == osr_of(int'(osr_code)) - 1) begin
                  m_per = 0; m_drdy = 0; m_low = DL;
                  if (m_outs == 2) m_valid = 1;
                  if (m_outs < 3) m_outs++;
               end else m_per++;
            end
         endcase
      end
   endtask

   task automatic compare();
      chk(filt_en == (m_ph == 2), en_tag, filt_en, m_ph == 2);
      chk(drdy_n == m_drdy, "R3 R4 R5 drdy_n", drdy_n, m_drdy);
      chk(fast_sel == (m_ph == 2 && m_outs < 2), "R6 fast_sel", fast_sel, m_ph == 2 && m_outs < 2);
      chk(data_valid == m_valid, "R7 data_valid", data_valid, m_valid);
      if (prev_drdy && !drdy_n) begin
         falls++;
         if (last_fall >= 0)
            chk(tick_total - last_fall == osr_of(int'(osr_code)), "R8 period",
                tick_total - last_fall, osr_of(int'(osr_code)));
         last_fall = tick_total;
      end
      prev_drdy = drdy_n;
   endtask

   task automatic step(input bit t, input bit c, input bit p);
      mod_tick = t; cmd_rst = c; pin_rst = p;
      @(posedge clk);
      model_edge(t, c | p);
      @(negedge clk);
      mod_tick = 0; cmd_rst = 0; pin_rst = 0;
      compare();
   endtask

   task automatic run_until_falls(input int want, input int dens);
      for (int i = 0; i < 60000 && falls < want; i++)
         step(($urandom % 100) < dens, 0, 0);
   endtask

   initial begin
      #(MAX_CYCLES * 4);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      tick_total = 0;
      model_por();
      repeat (3) @(negedge clk);
      // R5: reset state
      chk(drdy_n == 1'b1, "R5 reset drdy_n", drdy_n, 1);
      chk(filt_en == 1'b0, "R1 reset filt_en", filt_en, 0);
      chk(data_valid == 1'b0, "R7 reset data_valid", data_valid, 0);
      por_n = 1'b1;

      // R1: power-on path, code 0, dense random ticks
      run_until_falls(4, 75);

      // R2: reset during the power-on wait skips the supply wait
      por_n = 1'b0; @(negedge clk); por_n = 1'b1; model_por();
      for (int i = 0; i < 100; i++) step(1, 0, 0);
      step(0, 1, 0);
      run_until_falls(3, 60);

      // R3 R4 R8: low codes under random ticks, alternating reset sources
      for (int c = 0; c < 4; c++) begin
         osr_code = 3'(c);
         step($urandom % 2, c % 2 == 0, c % 2 == 1);
         run_until_falls(5, 40 + 15 * c);
      end

      // R9: reset in mid-run, coincident with a tick
      osr_code = 3'd1;
      step(1, 0, 1);
      run_until_falls(3, 80);
      step(1, 1, 0);
      chk(filt_en == 0 && drdy_n == 1 && data_valid == 0 && fast_sel == 0,
          "R9 restart outputs", {filt_en, drdy_n, data_valid, fast_sel}, 4'b0100);

      // R8: large codes with back-to-back ticks
      for (int c = 4; c < 8; c++) begin
         osr_code = 3'(c);
         step(0, c % 2 == 1, c % 2 == 0);
         run_until_falls(2, 100);
         chk(falls >= 2, "R8 two strobes seen", falls, 2);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule